// File: doc/BRIEF.md
# Split-Boundary Wide Signed Adder

This block forms a 52-bit two's-complement sum from a pair of 18-bit signed factors and one or two 52-bit signed operands. It has no single full-width carry chain. A fixed 44-bit lower adder takes the low part of the wide operand(s) together with the sign-extended product. A short upper adder then rebuilds the top bits from three inputs: the high slices of the wide operand(s), the carry out of the lower adder, and a sign correction for the product.

A parameter fixes the operating mode at build time. In two-operand mode the result is `c + a*b`. It is captured in one output register, so it appears one clock edge after the inputs. In three-operand mode the result is `c + d + a*b`. The inputs, the lower-stage sum and the output are each registered, which gives a latency of three edges. New operands can be applied on every cycle in both modes.

Top module: `wide_sadd`

## Requirements
- R1: While `rst_n` is low the result output is zero (asynchronous, active-low reset).
- R2: In two-operand mode (`THREE_IN`=0) the result equals `(c + a*b) mod 2^52`, with `a` and `b` 18-bit signed and `c` 52-bit signed.
- R3: In two-operand mode the result for a set of inputs is visible after the first rising edge that samples them (latency 1).
- R4: In two-operand mode the result is formed in two pieces. Bits 43:0 are the low 44 bits of `c[43:0]` plus the product sign-extended to 44 bits. Bits 51:44 are `c[51:44]` plus the carry out of bit 43, plus all ones when the product is negative.
- R5: In three-operand mode (`THREE_IN`=1) the result equals `(c + d + a*b) mod 2^52`.
- R6: In three-operand mode the result for a set of inputs is visible after the third rising edge that follows their sampling edge, counting the sampling edge as the first (latency 3).
- R7: In three-operand mode the lower adder takes `c[42:0]` and `d[42:0]`, each zero-extended to 44 bits, plus the 44-bit product. The 9-bit upper sum covers `c[51:43] + d[51:43]` plus a correction made of two parts: the 2-bit value {lower carry, lower bit 43}, and minus 2 when the product is negative.
- R8: In two-operand mode the input `d` has no effect on the result.
- R9: The most negative inputs (`a` = `b` = -2^17, `c` = `d` = -2^51) and the most positive inputs give the exact wrapped sum.
- R10: When either factor is zero the result equals `c` (two-operand mode) or `c + d` wrapped to 52 bits (three-operand mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 18 | Signed factor |
| b | input | 18 | Signed factor |
| c | input | 52 | Signed wide operand |
| d | input | 52 | Second signed wide operand (three-operand mode only) |
| result | output | 52 | Registered signed sum |

## Verification
The bench targets a carry rippling out of bit 43 into the upper slice. A design that dropped or mis-weighted that carry would be off by exactly 2^44. It also targets negative products small enough that the lower sum never carries, such as `c`=0 with `a*b`=-1. A correction built only from the carry and the lower sign bit would leave the top bits zero there instead of all ones. The most negative factor pair produces the positive product 2^34, and extreme wide operands wrap across bit 51. A design that treated the product as unsigned, or kept more than 52 bits, would fail on those. In the three-operand variant the bench also checks `d` operands whose bit 43 is set, because a design that split at bit 44 instead of bit 43 would count those bits twice or lose them.

// File: rtl/wide_sadd.sv
module wide_sadd #(
  parameter int OP_W     = 18,
  parameter int WIDE_W   = 52,
  parameter int LO_W     = 44,
  parameter bit THREE_IN = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [OP_W-1:0]   a,
  input  logic signed [OP_W-1:0]   b,
  input  logic signed [WIDE_W-1:0] c,
  input  logic signed [WIDE_W-1:0] d,
  output logic        [WIDE_W-1:0] result
);
  localparam int PROD_W = 2 * OP_W;
  localparam int HI_W   = WIDE_W - LO_W;
  localparam int EXT_W  = LO_W - PROD_W;

  generate
    if (!THREE_IN) begin : g_two
      logic signed [PROD_W-1:0] prod;
      logic        [LO_W-1:0]   prod_lo;
      logic        [LO_W:0]     lo_sum;
      logic        [HI_W-1:0]   corr;
      logic        [HI_W-1:0]   hi_sum;
      logic                     d_unused;

      assign prod     = a * b;
      assign prod_lo  = {{EXT_W{prod[PROD_W-1]}}, prod};
      assign lo_sum   = {1'b0, c[LO_W-1:0]} + {1'b0, prod_lo};
      assign corr     = {HI_W{prod[PROD_W-1]}} + {{(HI_W-1){1'b0}}, lo_sum[LO_W]};
      assign hi_sum   = c[WIDE_W-1:LO_W] + corr;
      assign d_unused = ^d;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result <= '0;
        else        result <= {hi_sum, lo_sum[LO_W-1:0]};
      end
    end else begin : g_three
      logic signed [OP_W-1:0]   a_q, b_q;
      logic        [WIDE_W-1:0] c_q, d_q;
      logic signed [PROD_W-1:0] prod;
      logic        [LO_W-1:0]   prod_lo;
      logic        [LO_W:0]     lo_sum;
      logic        [LO_W-1:0]   lo_q;
      logic                     cy_q, neg_q;
      logic        [HI_W:0]     ch_q, dh_q;
      logic        [HI_W:0]     corr;
      logic        [HI_W:0]     hi_sum;

      assign prod    = a_q * b_q;
      assign prod_lo = {{EXT_W{prod[PROD_W-1]}}, prod};
      assign lo_sum  = {2'b00, c_q[LO_W-2:0]} + {2'b00, d_q[LO_W-2:0]} + {1'b0, prod_lo};
      assign corr    = {{(HI_W-1){1'b0}}, cy_q, lo_q[LO_W-1]} + {{HI_W{neg_q}}, 1'b0};
      assign hi_sum  = ch_q + dh_q + corr;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_q    <= '0;
          b_q    <= '0;
          c_q    <= '0;
          d_q    <= '0;
          lo_q   <= '0;
          cy_q   <= 1'b0;
          neg_q  <= 1'b0;
          ch_q   <= '0;
          dh_q   <= '0;
          result <= '0;
        end else begin
          a_q    <= a;
          b_q    <= b;
          c_q    <= c;
          d_q    <= d;
          lo_q   <= lo_sum[LO_W-1:0];
          cy_q   <= lo_sum[LO_W];
          neg_q  <= prod[PROD_W-1];
          ch_q   <= c_q[WIDE_W-1:LO_W-1];
          dh_q   <= d_q[WIDE_W-1:LO_W-1];
          result <= {hi_sum, lo_q[LO_W-2:0]};
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wide_sadd_chk.sv
module wide_sadd_chk #(
  parameter int OP_W     = 18,
  parameter int WIDE_W   = 52,
  parameter int LO_W     = 44,
  parameter bit THREE_IN = 1'b0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic signed [OP_W-1:0]   a,
  input logic signed [OP_W-1:0]   b,
  input logic signed [WIDE_W-1:0] c,
  input logic signed [WIDE_W-1:0] d,
  input logic        [WIDE_W-1:0] result
);
  localparam int PROD_W = 2 * OP_W;

  logic signed [PROD_W-1:0] p;
  logic        [WIDE_W-1:0] m2, m3, cd;
  logic        [1:0]        seen;

  assign p  = a * b;
  assign m2 = c + {{(WIDE_W-PROD_W){p[PROD_W-1]}}, p};
  assign m3 = m2 + d;
  assign cd = c + d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen <= 2'd0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> result == '0);

  generate
    if (!THREE_IN) begin : g_two
      a_r2_sum: assert property (@(posedge clk) disable iff (!rst_n)
        seen != 2'd0 |-> result == $past(m2));
      a_r4_low_part: assert property (@(posedge clk) disable iff (!rst_n)
        seen != 2'd0 |-> result[LO_W-1:0] == $past(m2[LO_W-1:0]));
      a_r10_zero_factor: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && ($past(a) == 0 || $past(b) == 0)) |-> result == $past(c));
    end else begin : g_three
      a_r5_sum: assert property (@(posedge clk) disable iff (!rst_n)
        seen == 2'd3 |-> result == $past(m3, 3));
      a_r7_low_part: assert property (@(posedge clk) disable iff (!rst_n)
        seen == 2'd3 |-> result[LO_W-2:0] == $past(m3[LO_W-2:0], 3));
      a_r10_zero_factor: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && ($past(a, 3) == 0 || $past(b, 3) == 0)) |-> result == $past(cd, 3));
    end
  endgenerate
endmodule

bind wide_sadd wide_sadd_chk #(
  .OP_W(OP_W), .WIDE_W(WIDE_W), .LO_W(LO_W), .THREE_IN(THREE_IN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .c(c), .d(d), .result(result)
);

// File: tb/wide_sadd_bench.sv
module wide_sadd_bench;
  localparam int CLK_P = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [17:0] a = '0, b = '0;
  logic signed [51:0] c = '0, d = '0;
  logic        [51:0] res2, res3;

  int    n_chk = 0, n_fail = 0;
  logic  [51:0] h0 = '0, h1 = '0, h2 = '0;
  string t0 = "R1", t1 = "R1", t2 = "R1";

  always #(CLK_P/2) clk = ~clk;

  wide_sadd #(.THREE_IN(1'b0)) u_wide_sadd (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .c(c), .d(d), .result(res2));
  wide_sadd #(.THREE_IN(1'b1)) u_wide_sadd_tri (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .c(c), .d(d), .result(res3));

  function automatic logic [51:0] ref2(logic signed [17:0] fa, logic signed [17:0] fb,
                                       logic signed [51:0] fc);
    longint s;
    s = longint'(fc) + longint'(fa) * longint'(fb);
    return s[51:0];
  endfunction

  function automatic logic [51:0] ref3(logic signed [17:0] fa, logic signed [17:0] fb,
                                       logic signed [51:0] fc, logic signed [51:0] fd);
    longint s;
    s = longint'(fc) + longint'(fd) + longint'(fa) * longint'(fb);
    return s[51:0];
  endfunction

  task automatic check(string tag, logic [51:0] act, logic [51:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic signed [17:0] sa, logic signed [17:0] sb,
                      logic signed [51:0] sc, logic signed [51:0] sd,
                      string tag2, string tag3);
    @(negedge clk);
    a = sa; b = sb; c = sc; d = sd;
    h2 = h1; t2 = t1;
    h1 = h0; t1 = t0;
    h0 = ref3(sa, sb, sc, sd); t0 = tag3;
    @(posedge clk);
    #(CLK_P/4);
    check(tag2, res2, ref2(sa, sb, sc));
    check(t2, res3, h2);
  endtask

  localparam logic signed [17:0] AMIN = 18'sh20000;
  localparam logic signed [17:0] AMAX = 18'sh1FFFF;
  localparam logic signed [51:0] CMIN = {1'b1, 51'd0};
  localparam logic signed [51:0] CMAX = {1'b0, {51{1'b1}}};
  localparam logic signed [51:0] LO1  = {8'h00, {44{1'b1}}};

  initial begin : watchdog
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #(CLK_P * 2 + 1);
    check("R1 reset two-operand", res2, 52'd0);
    check("R1 reset three-operand", res3, 52'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R6 latency with a distinct pattern, R2 R5 basic sums
    step(18'sd3, 18'sd5, 52'sd100, 52'sd7, "R3 latency", "R6 latency");
    step(18'sd0, 18'sd0, 52'sd0, 52'sd0, "R3 follow", "R6 follow");
    step(-18'sd4, 18'sd9, 52'sd1, -52'sd3, "R2 mixed", "R5 mixed");
    // R4 carry out of bit 43
    step(18'sd1, 18'sd1, LO1, 52'sd0, "R4 carry into bit 44", "R7 carry");
    step(-18'sd1, 18'sd1, 52'sd0, 52'sd0, "R4 negative product no carry", "R7 negative product");
    step(-18'sd1, 18'sd1, LO1, LO1, "R4 negative product with carry", "R7 both high slices");
    step(18'sd2, -18'sd3, {8'h7F, 44'd1}, {8'h00, 1'b1, 43'd0}, "R4 borrow", "R7 bit43 of d");
    step(18'sd0, 18'sd0, {8'h00, 1'b1, 43'd0}, {8'h00, 1'b1, 43'd0}, "R10 zero factor", "R7 bit43 both");
    // R9 extremes
    step(AMIN, AMIN, CMIN, CMIN, "R9 most negative", "R9 most negative");
    step(AMIN, AMAX, CMAX, CMAX, "R9 extreme mixed", "R9 extreme mixed");
    step(AMAX, AMAX, CMAX, CMIN, "R9 most positive", "R9 most positive");
    // R8 d ignored in two-operand mode, R10 zero factor
    step(18'sd77, 18'sd0, -52'sd12345, 52'sd999, "R10 zero factor", "R10 zero factor");
    step(18'sd123, -18'sd45, 52'sd6789, 52'sd0, "R8 d zero", "R5 d zero");
    step(18'sd123, -18'sd45, 52'sd6789, CMIN, "R8 d changed", "R5 d changed");
    step(18'sd123, -18'sd45, 52'sd6789, CMAX, "R8 d changed again", "R5 d max");

    for (int i = 0; i < 3000; i++) begin
      logic signed [17:0] ra, rb;
      logic signed [51:0] rc, rd;
      ra = 18'($urandom);
      rb = 18'($urandom);
      rc = {20'($urandom), 32'($urandom)};
      rd = {20'($urandom), 32'($urandom)};
      if (i % 4 == 1) rc[43:0] = {44{1'b1}};
      if (i % 8 == 3) rd = -rc;
      if (i % 16 == 5) ra = AMIN;
      step(ra, rb, rc, rd, "R2 R8 random", "R5 random");
    end
    for (int i = 0; i < 3; i++)
      step(18'sd0, 18'sd0, 52'sd0, 52'sd0, "R2 drain", "R6 drain");

    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_P/4);
    check("R1 reset reassert two-operand", res2, 52'd0);
    check("R1 reset reassert three-operand", res3, 52'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule